// File: doc/BRIEF.md
# AUX Channel Transaction Sequencer

This block carries one request across a DisplayPort auxiliary channel for a host. The host supplies a command code, a 20-bit target address, a byte count from 1 to 16 and up to sixteen bytes of write data packed into four 32-bit words, then pulses `start`. The sequencer first takes ownership of the channel and confirms the grant. It then polls the channel for readiness a bounded number of times. Next it launches the request with a clearing pulse followed by a go strobe, and waits for the channel to report that the go has completed.

After a settling delay the sequencer samples the reply. A DEFER answer at the AUX level causes the request to be issued again, up to a parameterised limit. Any other answer ends the transaction. On every exit path, including the error paths, ownership is released and the release is confirmed. A final settling delay runs before `done` is pulsed together with the reply code, any read data and an error code.

All waits are cycle counts derived from a clock-frequency parameter, so the same RTL serves any clock. The channel side is a plain level and pulse handshake, which a behavioural sink model can drive directly.

Top module: `aux_xact_seq`

## Requirements
- R1: After reset, `busy`, `done`, `own_req`, `line_rst` and `xfer_go` are low, and `err`, `reply`, `rdata` and `req_wdata` are zero.
- R2: `start` is accepted only while `busy` is low. `busy` is high from the cycle after an accepted `start` until the single cycle in which `done` is high. A `start` raised while busy launches no further transaction.
- R3: `own_req` rises before any request activity and covers every `line_rst` and `xfer_go`. If `own_ack` is low `ACK_WAIT` cycles later, no request is issued and `err` = 1 (I/O error).
- R4: `chan_ready` is sampled at most `POLL_TRIES` (default 3) times, spaced by the poll interval. If it is never seen high, no request is issued and `err` = 2 (busy error).
- R5: The request presents `req_cmd` = `cmd`, `req_addr` = `addr` and `req_len` = byte count minus one, in 4 bits (16 bytes gives 15, 1 byte gives 0).
- R6: Bit 0 of `cmd` selects the direction. When it is 0 (write), all four data words appear on `req_wdata` before the first `line_rst` and `rdata` stays zero. When it is 1 (read), `req_wdata` stays zero and `rdata` holds `aux_rdata` as sampled on the final non-DEFER reply.
- R7: Each attempt is a one-cycle `line_rst`, followed by `xfer_go` held high until `xfer_done`. If `xfer_done` does not arrive within `GO_TIMEOUT` cycles, the transaction ends with `err` = 2.
- R8: A reply whose bits [1:0] equal 2'b10 (AUX DEFER) re-issues the request. Any other value ends the transaction, including a value that carries a defer code only in bits [3:2]. `reply` reports the last sampled code.
- R9: After `MAX_DEFER` re-issues (default 7, so 8 attempts in all) that are still answered with DEFER, the transaction ends with `err` = 3 (timeout).
- R10: Before `done`, `own_req` is dropped. If `own_ack` is still high `ACK_WAIT` cycles later, `err` is forced to 1.
- R11: The reply is sampled only after a settle delay of `SETTLE_US` following `xfer_done`. A second delay of the same length separates the release from `done`, so `done` comes at least two settle delays after the last `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| cmd | input | 4 | Command code; bit 0 = 1 means read |
| addr | input | 20 | Target address |
| len | input | 5 | Byte count, 1 to 16 |
| wdata | input | 128 | Write data, four 32-bit words |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 none, 1 I/O, 2 busy, 3 timeout |
| reply | output | 4 | Last sampled reply code |
| rdata | output | 128 | Captured read words |
| own_req | output | 1 | Channel ownership request |
| own_ack | input | 1 | Ownership grant from channel |
| chan_ready | input | 1 | Channel ready status |
| req_cmd | output | 4 | Command presented to channel |
| req_addr | output | 20 | Address presented to channel |
| req_len | output | 4 | Byte count minus one |
| req_wdata | output | 128 | Outgoing data words |
| line_rst | output | 1 | Clearing pulse that opens each attempt |
| xfer_go | output | 1 | Go strobe, held until completion |
| xfer_done | input | 1 | Channel reports the go bit cleared |
| aux_reply | input | 4 | Reply code from channel |
| aux_rdata | input | 128 | Incoming data words |

## Verification
The main path is exercised with a full 16-byte write and a 1-byte read. This pair separates the staging of outgoing words from the capture of incoming ones, and checks both ends of the length encoding. The sink is then made to answer DEFER a few times and then forever, which separates ordinary retry from the retry cap. It also answers NACK and a reply that carries a defer code only in the upper bits, which shows that only the AUX-level field triggers a retry. The fault patterns include:
- a grant that never comes;
- a grant that never drops;
- readiness that arrives only in time for the last poll, or never;
- a go that never completes.

Each fault maps to exactly one error code, and each shows whether a request reached the channel.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;

   typedef enum logic [1:0] {
      AUX_OK          = 2'd0,
      AUX_ERR_IO      = 2'd1,
      AUX_ERR_BUSY    = 2'd2,
      AUX_ERR_TIMEOUT = 2'd3
   } aux_err_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_OWN,
      ST_POLL,
      ST_POLL_WAIT,
      ST_LOAD,
      ST_KICK_RST,
      ST_KICK_GO,
      ST_SETTLE,
      ST_SAMPLE,
      ST_RELEASE,
      ST_TAIL,
      ST_DONE
   } seq_state_e;

   // AUX-level reply field value that asks for a retry
   localparam logic [1:0] AUX_RPL_DEFER = 2'b10;

   function automatic int unsigned us_to_cycles(input int unsigned khz,
                                                input int unsigned us);
      int unsigned r;
      r = (khz * us) / 1000;
      return (r == 0) ? 1 : r;
   endfunction

   function automatic int unsigned max_of(input int unsigned a,
                                          input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

   // once expired the timer stays expired until reloaded
   AST_TMR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && zero) |=> zero); // R11

endmodule

// File: rtl/aux_word_bank.sv
module aux_word_bank #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned N_WORDS = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear,
   input  logic                        load_out,
   input  logic [WORD_W*N_WORDS-1:0]   out_src,
   input  logic                        cap_in,
   input  logic [WORD_W*N_WORDS-1:0]   in_src,
   output logic [WORD_W*N_WORDS-1:0]   out_words,
   output logic [WORD_W*N_WORDS-1:0]   in_words
);

   if (N_WORDS < 1 || WORD_W < 8) begin : g_bad_shape
      $error("aux_word_bank: N_WORDS must be >= 1 and WORD_W >= 8");
   end

   for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_word
      logic [WORD_W-1:0] out_q;
      logic [WORD_W-1:0] in_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_q <= '0;
            in_q  <= '0;
         end else begin
            if (clear) begin
               out_q <= '0;
            end else if (load_out) begin
               out_q <= out_src[gi*WORD_W +: WORD_W];
            end
            if (clear) begin
               in_q <= '0;
            end else if (cap_in) begin
               in_q <= in_src[gi*WORD_W +: WORD_W];
            end
         end
      end

      assign out_words[gi*WORD_W +: WORD_W] = out_q;
      assign in_words[gi*WORD_W +: WORD_W]  = in_q;
   end

   AST_LOAD_CAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_out && cap_in)); // R6

   AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !load_out) |=> $stable(out_words)); // R6

endmodule

// File: rtl/aux_xact_seq.sv
module aux_xact_seq
   import aux_xact_pkg::*;
#(
   parameter int unsigned CLK_KHZ    = 200000,
   parameter int unsigned POLL_US    = 100,
   parameter int unsigned SETTLE_US  = 400,
   parameter int unsigned ACK_WAIT   = 4,
   parameter int unsigned GO_TIMEOUT = 1000,
   parameter int unsigned POLL_TRIES = 3,
   parameter int unsigned MAX_DEFER  = 7,
   parameter int unsigned ADDR_W     = 20,
   parameter int unsigned CMD_W      = 4,
   parameter int unsigned RPL_W      = 4,
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned N_WORDS    = 4,
   parameter int unsigned MAX_BYTES  = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [CMD_W-1:0]              cmd,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [$clog2(MAX_BYTES):0]    len,
   input  logic [WORD_W*N_WORDS-1:0]     wdata,
   output logic                          busy,
   output logic                          done,
   output logic [1:0]                    err,
   output logic [RPL_W-1:0]              reply,
   output logic [WORD_W*N_WORDS-1:0]     rdata,
   output logic                          own_req,
   input  logic                          own_ack,
   input  logic                          chan_ready,
   output logic [CMD_W-1:0]              req_cmd,
   output logic [ADDR_W-1:0]             req_addr,
   output logic [$clog2(MAX_BYTES)-1:0]  req_len,
   output logic [WORD_W*N_WORDS-1:0]     req_wdata,
   output logic                          line_rst,
   output logic                          xfer_go,
   input  logic                          xfer_done,
   input  logic [RPL_W-1:0]              aux_reply,
   input  logic [WORD_W*N_WORDS-1:0]     aux_rdata
);

   localparam int unsigned DATA_W     = WORD_W * N_WORDS;
   localparam int unsigned LEN_W      = $clog2(MAX_BYTES) + 1;
   localparam int unsigned LENF_W     = $clog2(MAX_BYTES);
   localparam int unsigned POLL_CYC   = us_to_cycles(CLK_KHZ, POLL_US);
   localparam int unsigned SETTLE_CYC = us_to_cycles(CLK_KHZ, SETTLE_US);
   localparam int unsigned MAX_WAIT   = max_of(max_of(POLL_CYC, SETTLE_CYC),
                                               max_of(GO_TIMEOUT, ACK_WAIT));
   localparam int unsigned TMR_W      = $clog2(MAX_WAIT + 1);
   localparam int unsigned PT_W       = $clog2(POLL_TRIES + 1);
   localparam int unsigned RTY_W      = $clog2(MAX_DEFER + 1);

   localparam logic [TMR_W-1:0] T_ACK    = TMR_W'(ACK_WAIT);
   localparam logic [TMR_W-1:0] T_POLL   = TMR_W'(POLL_CYC);
   localparam logic [TMR_W-1:0] T_SETTLE = TMR_W'(SETTLE_CYC);
   localparam logic [TMR_W-1:0] T_GO     = TMR_W'(GO_TIMEOUT);
   localparam logic [PT_W-1:0]  PT_LAST  = PT_W'(POLL_TRIES - 1);
   localparam logic [RTY_W-1:0] RTY_LAST = RTY_W'(MAX_DEFER);

   // ---------------- elaboration checks ----------------
   if (MAX_BYTES * 8 != DATA_W) begin : g_bad_data
      $error("aux_xact_seq: WORD_W*N_WORDS must hold MAX_BYTES bytes");
   end
   if (POLL_TRIES < 1 || MAX_DEFER < 1) begin : g_bad_counts
      $error("aux_xact_seq: POLL_TRIES and MAX_DEFER must be >= 1");
   end
   if (ACK_WAIT < 1 || GO_TIMEOUT < 1) begin : g_bad_waits
      $error("aux_xact_seq: ACK_WAIT and GO_TIMEOUT must be >= 1");
   end
   if (CMD_W < 1 || RPL_W < 2 || ADDR_W < 1) begin : g_bad_fields
      $error("aux_xact_seq: field widths too small");
   end

   // ---------------- state ----------------
   seq_state_e         state_q, state_d;
   aux_err_e           err_q, err_val;
   logic [CMD_W-1:0]   cmd_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [LENF_W-1:0]  lenf_q;
   logic [DATA_W-1:0]  wdata_q;
   logic [RPL_W-1:0]   rpl_q;
   logic [PT_W-1:0]    poll_cnt_q;
   logic [RTY_W-1:0]   rty_cnt_q;
   logic [LEN_W-1:0]   len_m1;

   logic               accept, poll_inc, rty_inc, load_out, cap_in, cap_rpl;
   logic               err_set;
   logic               tmr_load, tmr_zero;
   logic [TMR_W-1:0]   tmr_val;
   logic               is_read, is_defer;

   assign len_m1   = len - 1'b1;
   assign is_read  = cmd_q[0];
   assign is_defer = (aux_reply[1:0] == AUX_RPL_DEFER);

   aux_wait_timer #(
      .CNT_W (TMR_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .val   (tmr_val),
      .zero  (tmr_zero)
   );

   aux_word_bank #(
      .WORD_W  (WORD_W),
      .N_WORDS (N_WORDS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .load_out  (load_out),
      .out_src   (wdata_q),
      .cap_in    (cap_in),
      .in_src    (aux_rdata),
      .out_words (req_wdata),
      .in_words  (rdata)
   );

   // ---------------- next-state logic ----------------
   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      accept   = 1'b0;
      poll_inc = 1'b0;
      rty_inc  = 1'b0;
      load_out = 1'b0;
      cap_in   = 1'b0;
      cap_rpl  = 1'b0;
      err_set  = 1'b0;
      err_val  = AUX_OK;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               accept   = 1'b1;
               state_d  = ST_OWN;
               tmr_load = 1'b1;
               tmr_val  = T_ACK;
            end
         end
         ST_OWN: begin
            if (tmr_zero) begin
               if (own_ack) begin
                  state_d = ST_POLL;
               end else begin
                  err_set  = 1'b1;
                  err_val  = AUX_ERR_IO;
                  state_d  = ST_RELEASE;
                  tmr_load = 1'b1;
                  tmr_val  = T_ACK;
               end
            end
         end
         ST_POLL: begin
            if (chan_ready) begin
               state_d = is_read ? ST_KICK_RST : ST_LOAD;
            end else if (poll_cnt_q == PT_LAST) begin
               err_set  = 1'b1;
               err_val  = AUX_ERR_BUSY;
               state_d  = ST_RELEASE;
               tmr_load = 1'b1;
               tmr_val  = T_ACK;
            end else begin
               poll_inc = 1'b1;
               state_d  = ST_POLL_WAIT;
               tmr_load = 1'b1;
               tmr_val  = T_POLL;
            end
         end
         ST_POLL_WAIT: begin
            if (tmr_zero) begin
               state_d = ST_POLL;
            end
         end
         ST_LOAD: begin
            load_out = 1'b1;
            state_d  = ST_KICK_RST;
         end
         ST_KICK_RST: begin
            state_d  = ST_KICK_GO;
            tmr_load = 1'b1;
            tmr_val  = T_GO;
         end
         ST_KICK_GO: begin
            if (xfer_done) begin
               state_d  = ST_SETTLE;
               tmr_load = 1'b1;
               tmr_val  = T_SETTLE;
            end else if (tmr_zero) begin
               err_set  = 1'b1;
               err_val  = AUX_ERR_BUSY;
               state_d  = ST_RELEASE;
               tmr_load = 1'b1;
               tmr_val  = T_ACK;
            end
         end
         ST_SETTLE: begin
            if (tmr_zero) begin
               state_d = ST_SAMPLE;
            end
         end
         ST_SAMPLE: begin
            cap_rpl = 1'b1;
            if (is_defer) begin
               if (rty_cnt_q == RTY_LAST) begin
                  err_set  = 1'b1;
                  err_val  = AUX_ERR_TIMEOUT;
                  state_d  = ST_RELEASE;
                  tmr_load = 1'b1;
                  tmr_val  = T_ACK;
               end else begin
                  rty_inc = 1'b1;
                  state_d = ST_KICK_RST;
               end
            end else begin
               cap_in   = is_read;
               state_d  = ST_RELEASE;
               tmr_load = 1'b1;
               tmr_val  = T_ACK;
            end
         end
         ST_RELEASE: begin
            if (tmr_zero) begin
               if (own_ack) begin
                  err_set = 1'b1;
                  err_val = AUX_ERR_IO;
               end
               state_d  = ST_TAIL;
               tmr_load = 1'b1;
               tmr_val  = T_SETTLE;
            end
         end
         ST_TAIL: begin
            if (tmr_zero) begin
               state_d = ST_DONE;
            end
         end
         ST_DONE: begin
            state_d = ST_IDLE;
         end
         default: begin
            state_d = ST_IDLE;
         end
      endcase
   end

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         err_q      <= AUX_OK;
         cmd_q      <= '0;
         addr_q     <= '0;
         lenf_q     <= '0;
         wdata_q    <= '0;
         rpl_q      <= '0;
         poll_cnt_q <= '0;
         rty_cnt_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            cmd_q      <= cmd;
            addr_q     <= addr;
            lenf_q     <= len_m1[LENF_W-1:0];
            wdata_q    <= wdata;
            rpl_q      <= '0;
            err_q      <= AUX_OK;
            poll_cnt_q <= '0;
            rty_cnt_q  <= '0;
         end else begin
            if (poll_inc) poll_cnt_q <= poll_cnt_q + 1'b1;
            if (rty_inc)  rty_cnt_q  <= rty_cnt_q + 1'b1;
            if (err_set)  err_q      <= err_val;
            if (cap_rpl)  rpl_q      <= aux_reply;
         end
      end
   end

   // ---------------- outputs ----------------
   assign busy     = (state_q != ST_IDLE);
   assign done     = (state_q == ST_DONE);
   assign line_rst = (state_q == ST_KICK_RST);
   assign xfer_go  = (state_q == ST_KICK_GO);
   assign own_req  = (state_q inside {ST_OWN, ST_POLL, ST_POLL_WAIT, ST_LOAD,
                                      ST_KICK_RST, ST_KICK_GO, ST_SETTLE,
                                      ST_SAMPLE});
   assign err      = err_q;
   assign reply    = rpl_q;
   assign req_cmd  = cmd_q;
   assign req_addr = addr_q;
   assign req_len  = lenf_q;

   // ---------------- assertions ----------------
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R2

   AST_REQ_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      (line_rst || xfer_go) |-> own_req); // R3

   AST_RST_THEN_GO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_go) |-> $past(line_rst)); // R7

   AST_DEFER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rty_cnt_q <= RTY_LAST); // R9

   AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      poll_cnt_q <= PT_LAST); // R4

   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |-> (len >= 1 && len <= LEN_W'(MAX_BYTES))); // R5

   AST_RELEASED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !own_req); // R10

endmodule

// File: tb/test_aux_xact_seq.sv
`timescale 1ns/1ps
module test_aux_xact_seq;

   localparam int unsigned CLK_KHZ    = 100;
   localparam int unsigned ACK_WAIT   = 3;
   localparam int unsigned GO_TIMEOUT = 20;
   localparam int unsigned MAX_DEFER  = 7;
   localparam int          SETTLE_CYC = 40;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [3:0]   cmd = '0;
   logic [19:0]  addr = '0;
   logic [4:0]   len = 5'd1;
   logic [127:0] wdata = '0;
   logic         busy, done;
   logic [1:0]   err;
   logic [3:0]   reply;
   logic [127:0] rdata;
   logic         own_req;
   logic         own_ack = 1'b0;
   logic         chan_ready = 1'b0;
   logic [3:0]   req_cmd;
   logic [19:0]  req_addr;
   logic [3:0]   req_len;
   logic [127:0] req_wdata;
   logic         line_rst, xfer_go;
   logic         xfer_done = 1'b0;
   logic [3:0]   aux_reply = '0;
   logic [127:0] aux_rdata = '0;

   aux_xact_seq #(
      .CLK_KHZ    (CLK_KHZ),
      .ACK_WAIT   (ACK_WAIT),
      .GO_TIMEOUT (GO_TIMEOUT),
      .MAX_DEFER  (MAX_DEFER)
   ) i_aux_xact_seq (
      .clk, .rst_n, .start, .cmd, .addr, .len, .wdata,
      .busy, .done, .err, .reply, .rdata,
      .own_req, .own_ack, .chan_ready,
      .req_cmd, .req_addr, .req_len, .req_wdata,
      .line_rst, .xfer_go, .xfer_done, .aux_reply, .aux_rdata
   );

   initial forever #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // sink model state
   int           cyc = 0;
   int           since_start = 0;
   int           rdy_mode = 0;     // 0 ready, 1 never, 2 after rdy_k cycles
   int           rdy_k = 0;
   int           ack_mode = 0;     // 0 follows, 1 never, 2 stuck high
   logic [1:0]   ack_p = '0;
   bit           sink_hang = 1'b0;
   int           go_cnt = 0;
   int           defer_left = 0;
   logic [3:0]   final_rpl = '0;
   int           attempts = 0;
   int           done_cnt = 0;
   int           last_xd = 0;
   int           done_at = 0;
   logic [3:0]   cap_cmd = '0;
   logic [19:0]  cap_addr = '0;
   logic [3:0]   cap_len = '0;
   logic [127:0] cap_wdata = '0;

   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (busy) since_start++; else since_start = 0;
         case (rdy_mode)
            0:       chan_ready = 1'b1;
            1:       chan_ready = 1'b0;
            default: chan_ready = (since_start >= rdy_k);
         endcase
         ack_p = {ack_p[0], own_req};
         case (ack_mode)
            1:       own_ack = 1'b0;
            2:       own_ack = 1'b1;
            default: own_ack = ack_p[1];
         endcase
         if (line_rst) begin
            attempts++;
            cap_cmd   = req_cmd;
            cap_addr  = req_addr;
            cap_len   = req_len;
            cap_wdata = req_wdata;
         end
         if (done) done_cnt++;
         xfer_done = 1'b0;
         if (xfer_go && !sink_hang) begin
            go_cnt++;
            if (go_cnt == 3) begin
               xfer_done = 1'b1;
               last_xd   = cyc;
               if (defer_left > 0) begin
                  aux_reply = 4'b0010;
                  defer_left--;
               end else begin
                  aux_reply = final_rpl;
               end
            end
         end else if (!xfer_go) begin
            go_cnt = 0;
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic set_modes(input int rm, input int rk, input int am,
                            input bit hang, input int dl, input logic [3:0] fr);
      rdy_mode   = rm;
      rdy_k      = rk;
      ack_mode   = am;
      sink_hang  = hang;
      defer_left = dl;
      final_rpl  = fr;
   endtask

   task automatic run_xact(input logic [3:0] c, input logic [19:0] a,
                           input logic [4:0] l, input logic [127:0] w,
                           input bit bump);
      int n;
      @(negedge clk);
      cmd = c; addr = a; len = l; wdata = w; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2", "busy after start", busy, 1);
      n = 0;
      while (!done && n < 4000) begin
         @(negedge clk);
         n++;
         if (bump && n == 10) begin
            start = 1'b1;
            addr  = a ^ 20'h1;
         end else begin
            start = 1'b0;
         end
      end
      done_at = cyc;
      chk("R2", "done reached", done, 1);
   endtask

   task automatic t_reset;
      chk("R1", "busy", busy, 0);
      chk("R1", "done", done, 0);
      chk("R1", "own_req", own_req, 0);
      chk("R1", "line_rst|xfer_go", line_rst | xfer_go, 0);
      chk("R1", "err", err, 0);
      chk("R1", "reply", reply, 0);
      chk("R1", "rdata", rdata, 0);
      chk("R1", "req_wdata", req_wdata, 0);
   endtask

   task automatic t_write;
      int a0;
      logic [127:0] w;
      w = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
      set_modes(0, 0, 0, 0, 0, 4'h0);
      a0 = attempts;
      run_xact(4'h8, 20'hABCDE, 5'd16, w, 0);
      chk("R5", "req_cmd", cap_cmd, 4'h8);
      chk("R5", "req_addr", cap_addr, 20'hABCDE);
      chk("R5", "req_len 16 bytes", cap_len, 4'd15);
      chk("R6", "write words staged", cap_wdata, w);
      chk("R6", "rdata on write", rdata, 0);
      chk("R8", "single attempt", attempts - a0, 1);
      chk("R8", "reply ack", reply, 0);
      chk("R10", "err none", err, 0);
      chk("R10", "own_req low at done", own_req, 0);
      chk("R11", "two settle delays", (done_at - last_xd) >= 2*SETTLE_CYC, 1);
   endtask

   task automatic t_read;
      int a0;
      logic [127:0] rd;
      rd = 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D;
      aux_rdata = rd;
      set_modes(0, 0, 0, 0, 0, 4'h0);
      a0 = attempts;
      run_xact(4'h9, 20'h00200, 5'd1, 128'hFFFF, 0);
      chk("R5", "req_len 1 byte", cap_len, 4'd0);
      chk("R6", "no outgoing words on read", cap_wdata, 0);
      chk("R6", "read data captured", rdata, rd);
      chk("R8", "single attempt read", attempts - a0, 1);
      chk("R10", "err none read", err, 0);
   endtask

   task automatic t_defer_some;
      int a0;
      set_modes(0, 0, 0, 0, 3, 4'h0);
      a0 = attempts;
      run_xact(4'h8, 20'h00010, 5'd2, 128'h1234, 0);
      chk("R8", "defer x3 then ack attempts", attempts - a0, 4);
      chk("R8", "reply after retries", reply, 0);
      chk("R8", "err after retries", err, 0);
   endtask

   task automatic t_defer_cap;
      int a0;
      set_modes(0, 0, 0, 0, 100, 4'h0);
      a0 = attempts;
      run_xact(4'h9, 20'h00011, 5'd4, 128'h0, 0);
      chk("R9", "attempts at cap", attempts - a0, MAX_DEFER + 1);
      chk("R9", "timeout error", err, 3);
      chk("R9", "reply defer", reply, 4'b0010);
      chk("R9", "no read capture on defer", rdata, 0);
   endtask

   task automatic t_codes;
      int a0;
      set_modes(0, 0, 0, 0, 0, 4'b1000);
      a0 = attempts;
      run_xact(4'h9, 20'h00050, 5'd1, 128'h0, 0);
      chk("R8", "upper-field defer not retried", attempts - a0, 1);
      chk("R8", "upper-field reply", reply, 4'b1000);
      set_modes(0, 0, 0, 0, 0, 4'b0001);
      a0 = attempts;
      run_xact(4'h8, 20'h00051, 5'd1, 128'h5A, 0);
      chk("R8", "nack not retried", attempts - a0, 1);
      chk("R8", "nack reply", reply, 4'b0001);
      chk("R8", "nack err none", err, 0);
   endtask

   task automatic t_own_fail;
      int a0;
      set_modes(0, 0, 1, 0, 0, 4'h0);
      a0 = attempts;
      run_xact(4'h8, 20'h00100, 5'd1, 128'h1, 0);
      chk("R3", "no request without grant", attempts - a0, 0);
      chk("R3", "io error", err, 1);
   endtask

   task automatic t_poll;
      int a0;
      set_modes(2, 22, 0, 0, 0, 4'h0);
      a0 = attempts;
      run_xact(4'h8, 20'h00200, 5'd1, 128'h2, 0);
      chk("R4", "ready on last poll", err, 0);
      chk("R4", "request issued after late ready", attempts - a0, 1);
      set_modes(2, 40, 0, 0, 0, 4'h0);
      a0 = attempts;
      run_xact(4'h8, 20'h00201, 5'd1, 128'h3, 0);
      chk("R4", "ready too late busy error", err, 2);
      chk("R4", "no request when not ready", attempts - a0, 0);
   endtask

   task automatic t_go_hang;
      int a0;
      set_modes(0, 0, 0, 1, 0, 4'h0);
      a0 = attempts;
      run_xact(4'h8, 20'h00300, 5'd1, 128'h4, 0);
      chk("R7", "go timeout busy error", err, 2);
      chk("R7", "one attempt before timeout", attempts - a0, 1);
   endtask

   task automatic t_rel_stuck;
      int a0;
      set_modes(0, 0, 2, 0, 0, 4'h0);
      a0 = attempts;
      run_xact(4'h8, 20'h00400, 5'd1, 128'h5, 0);
      chk("R10", "grant stuck gives io error", err, 1);
      chk("R10", "transfer still ran", attempts - a0, 1);
   endtask

   task automatic t_busy_ignore;
      int a0, d0;
      set_modes(0, 0, 0, 0, 0, 4'h0);
      a0 = attempts;
      d0 = done_cnt;
      run_xact(4'h8, 20'h00500, 5'd1, 128'h6, 1);
      repeat (20) @(negedge clk);
      chk("R2", "start while busy ignored attempts", attempts - a0, 1);
      chk("R2", "first address kept", cap_addr, 20'h00500);
      chk("R2", "single done pulse", done_cnt - d0, 1);
      chk("R2", "idle afterwards", busy, 0);
   endtask

   task automatic run_all;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_write();
      t_read();
      t_defer_some();
      t_defer_cap();
      t_codes();
      t_own_fail();
      t_poll();
      t_go_hang();
      t_rel_stuck();
      t_busy_ignore();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual hung expected done");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule